// File: doc/BRIEF.md
# MDIO Management Bus Master

This block is the station-management master for an Ethernet PHY. It runs one read or one write frame per host request over a two-wire management link. The link is made of a management clock (MDC) and a bidirectional data line, which is split at the ports into an output value, an output enable and an input. A host starts a frame with a one-cycle request. With the request it gives a read/write flag, a 5-bit PHY address, a 5-bit register address and, for a write, 16 data bits. The block raises `busy` until the frame ends. It then pulses `done`, and at that point `rdata` and `err` hold the outcome.

The MDC half-period is a whole number of system clocks. A 16-bit divider input sets it and is captured when the request is accepted. During a read, the master checks that the PHY pulls the line low in the first turnaround slot. If the PHY stays silent, the master clocks a recovery burst and reports an error instead of data. Every frame ends with the data line released, and MDC rests high while the block is idle.

Top module: `mdio_master`

## Requirements
- R1: Every frame opens with 32 MDC cycles in which the data line is driven (enable 1) to logic 1.
- R2: After the opening burst, 14 driven bits follow: start pattern 0,1; then the opcode, which is 1,0 for a read (`rd_wr`=1) and 0,1 for a write; then the PHY address MSB first; then the register address MSB first.
- R3: Output value and output enable change only in the system cycle where MDC goes low, or while MDC is low. Each MDC low phase and each high phase lasts max(`half_div`,1) system clocks, so a frame keeps `busy` high for 2·max(`half_div`,1)·(number of MDC cycles) clocks.
- R4: A write drives the turnaround bits 1 then 0, then the 16 data bits MSB first. It then gives one more MDC cycle with the line released. A write frame has 65 MDC cycles.
- R5: A read releases the line from the first turnaround slot onward and samples the input at the end of each MDC high phase. If the first turnaround sample is 0, one more released turnaround slot follows, then 16 data bits MSB first, then one trailing MDC cycle. `rdata` then holds the 16 bits, `err` is 0, and the frame has 65 MDC cycles.
- R6: If the first turnaround sample of a read is 1, the master clocks 32 more released MDC cycles (79 in all) and sets `err` to 1. `rdata` keeps its previous value.
- R7: `done` is a single-cycle pulse at the end of a frame. `busy` is high from the cycle after the accepting edge until `done`, and is low in the `done` cycle.
- R8: A request that arrives while `busy` is high is ignored. The frame in progress keeps its length and its bits, and no second frame follows it.
- R9: After reset, and whenever the block is idle, MDC is 1 and the output enable is 0. After reset, `busy`, `done`, `err` and `rdata` are 0.
- R10: A request presented in the `done` cycle is accepted, and `busy` is high in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| half_div | input | 16 | MDC half-period in system clocks (0 acts as 1), captured on accept |
| req | input | 1 | Start request, sampled when idle |
| rd_wr | input | 1 | 1 = read frame, 0 = write frame |
| phy_addr | input | 5 | Target PHY address |
| reg_addr | input | 5 | Target register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Data from the last successful read |
| done | output | 1 | One-cycle end-of-frame pulse |
| err | output | 1 | Last read found no PHY response |
| busy | output | 1 | Frame in progress |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input |

## Verification
The end of one frame and the acceptance of the next can fall in the same system cycle. The bench provokes this by presenting a read request exactly in the cycle where `done` of a write is seen. It judges the result from `busy` in the following cycle and from the complete bit stream and length of the read frame that follows. A second overlap is a request that lands during a frame. That case is judged by checking that the running write keeps its 65 captured bits and its clock count, and that `busy` stays low after its `done`.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_HDR,
    ST_TA,
    ST_WDAT,
    ST_RDAT,
    ST_TAIL,
    ST_RECOV
  } mdio_st_e;

  localparam logic [1:0] SOF_BITS = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_WRITE = 2'b01;

endpackage

// File: rtl/mdio_halfdiv.sv
module mdio_halfdiv #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             run,
  input  logic [DIV_W-1:0] div_in,
  output logic             tick
);

  logic [DIV_W-1:0] lim_q;
  logic [DIV_W-1:0] cnt_q;

  assign tick = run && (cnt_q == lim_q - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      lim_q <= DIV_W'(1);
      cnt_q <= '0;
    end else if (restart) begin
      lim_q <= (div_in == '0) ? DIV_W'(1) : div_in;
      cnt_q <= '0;
    end else if (run) begin
      cnt_q <= tick ? '0 : cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/mdio_rxshift.sv
module mdio_rxshift #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          shift_en,
  input  logic          bit_in,
  input  logic          commit,
  output logic [DW-1:0] data_o
);

  logic [DW-1:0] sr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q   <= '0;
      data_o <= '0;
    end else begin
      if (shift_en) sr_q <= {sr_q[DW-2:0], bit_in};
      if (commit)   data_o <= sr_q;
    end
  end

endmodule

// File: rtl/mdio_framer.sv
module mdio_framer
  import mdio_pkg::*;
#(
  parameter int PRE_N   = 32,
  parameter int RECOV_N = 32,
  parameter int AW      = 5,
  parameter int DW      = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic          rd_wr,
  input  logic [AW-1:0] phy_addr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] wdata,
  input  logic          tick,
  input  logic          mdio_i,
  output logic          accept,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic          mdc,
  output logic          mdio_o,
  output logic          mdio_oe,
  output logic          sample_en,
  output logic          rd_commit
);

  localparam int HDR_N = 4 + 2 * AW;
  localparam int M1    = (PRE_N > RECOV_N) ? PRE_N : RECOV_N;
  localparam int M2    = (DW > HDR_N) ? DW : HDR_N;
  localparam int MAXN  = (M1 > M2) ? M1 : M2;
  localparam int CW    = $clog2(MAXN);

  mdio_st_e         st_q, st_n;
  logic [CW-1:0]    cnt_q, cnt_n;
  logic [HDR_N-1:0] hdr_q;
  logic [DW-1:0]    wd_q;
  logic             is_rd_q, bad_q;
  logic             o_n, oe_n, fin, bad_n, sh_hdr, sh_wd;
  logic             hi_end, lo_end;

  assign accept    = req && !busy;
  assign hi_end    = tick && mdc;
  assign lo_end    = tick && !mdc;
  assign sample_en = hi_end && (st_q == ST_RDAT);
  assign rd_commit = hi_end && fin && is_rd_q && !bad_q;

  // Choice of the next MDC slot, evaluated at the end of each high phase
  always_comb begin
    st_n   = st_q;
    cnt_n  = cnt_q - 1'b1;
    o_n    = mdio_o;
    oe_n   = mdio_oe;
    fin    = 1'b0;
    bad_n  = 1'b0;
    sh_hdr = 1'b0;
    sh_wd  = 1'b0;
    case (st_q)
      ST_PRE: begin
        if (cnt_q == '0) begin
          st_n  = ST_HDR;
          cnt_n = CW'(HDR_N - 1);
          o_n   = hdr_q[HDR_N-1];
        end
      end
      ST_HDR: begin
        sh_hdr = 1'b1;
        o_n    = hdr_q[HDR_N-2];
        if (cnt_q == '0) begin
          st_n  = ST_TA;
          cnt_n = CW'(1);
          o_n   = 1'b1;
          oe_n  = !is_rd_q;
        end
      end
      ST_TA: begin
        if (cnt_q == CW'(1)) begin
          if (is_rd_q && mdio_i) begin
            st_n  = ST_RECOV;
            cnt_n = CW'(RECOV_N - 1);
            bad_n = 1'b1;
          end else if (!is_rd_q) begin
            o_n = 1'b0;
          end
        end else begin
          st_n  = is_rd_q ? ST_RDAT : ST_WDAT;
          cnt_n = CW'(DW - 1);
          if (!is_rd_q) o_n = wd_q[DW-1];
        end
      end
      ST_WDAT: begin
        sh_wd = 1'b1;
        o_n   = wd_q[DW-2];
        if (cnt_q == '0) begin
          st_n  = ST_TAIL;
          cnt_n = '0;
          o_n   = 1'b1;
          oe_n  = 1'b0;
        end
      end
      ST_RDAT: begin
        if (cnt_q == '0) begin
          st_n  = ST_TAIL;
          cnt_n = '0;
        end
      end
      ST_TAIL:  fin = 1'b1;
      ST_RECOV: if (cnt_q == '0) fin = 1'b1;
      default:  st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      hdr_q   <= '0;
      wd_q    <= '0;
      is_rd_q <= 1'b0;
      bad_q   <= 1'b0;
      busy    <= 1'b0;
      done    <= 1'b0;
      err     <= 1'b0;
      mdc     <= 1'b1;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        st_q    <= ST_PRE;
        cnt_q   <= CW'(PRE_N - 1);
        hdr_q   <= {SOF_BITS, (rd_wr ? OP_READ : OP_WRITE), phy_addr, reg_addr};
        wd_q    <= wdata;
        is_rd_q <= rd_wr;
        bad_q   <= 1'b0;
        busy    <= 1'b1;
        err     <= 1'b0;
        mdc     <= 1'b0;
        mdio_o  <= 1'b1;
        mdio_oe <= 1'b1;
      end else if (lo_end) begin
        mdc <= 1'b1;
      end else if (hi_end) begin
        if (fin) begin
          st_q    <= ST_IDLE;
          busy    <= 1'b0;
          done    <= 1'b1;
          err     <= bad_q;
          mdio_o  <= 1'b1;
          mdio_oe <= 1'b0;
        end else begin
          st_q    <= st_n;
          cnt_q   <= cnt_n;
          mdc     <= 1'b0;
          mdio_o  <= o_n;
          mdio_oe <= oe_n;
          if (bad_n)  bad_q <= 1'b1;
          if (sh_hdr) hdr_q <= {hdr_q[HDR_N-2:0], 1'b0};
          if (sh_wd)  wd_q  <= {wd_q[DW-2:0], 1'b0};
        end
      end
    end
  end

endmodule

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int DIV_W   = 16,
  parameter int PRE_N   = 32,
  parameter int RECOV_N = 32,
  parameter int AW      = 5,
  parameter int DW      = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] half_div,
  input  logic             req,
  input  logic             rd_wr,
  input  logic [AW-1:0]    phy_addr,
  input  logic [AW-1:0]    reg_addr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  output logic             done,
  output logic             err,
  output logic             busy,
  output logic             mdc,
  output logic             mdio_o,
  output logic             mdio_oe,
  input  logic             mdio_i
);

  logic accept, tick, sample_en, rd_commit;

  mdio_halfdiv #(.DIV_W(DIV_W)) u_div (
    .clk     (clk),
    .rst     (rst),
    .restart (accept),
    .run     (busy),
    .div_in  (half_div),
    .tick    (tick)
  );

  mdio_framer #(
    .PRE_N   (PRE_N),
    .RECOV_N (RECOV_N),
    .AW      (AW),
    .DW      (DW)
  ) u_frm (
    .clk       (clk),
    .rst       (rst),
    .req       (req),
    .rd_wr     (rd_wr),
    .phy_addr  (phy_addr),
    .reg_addr  (reg_addr),
    .wdata     (wdata),
    .tick      (tick),
    .mdio_i    (mdio_i),
    .accept    (accept),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .sample_en (sample_en),
    .rd_commit (rd_commit)
  );

  mdio_rxshift #(.DW(DW)) u_rx (
    .clk      (clk),
    .rst      (rst),
    .shift_en (sample_en),
    .bit_in   (mdio_i),
    .commit   (rd_commit),
    .data_o   (rdata)
  );

endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic clk,
  input logic rst,
  input logic req,
  input logic busy,
  input logic done,
  input logic err,
  input logic mdc,
  input logic mdio_o,
  input logic mdio_oe
);

  // R3: line value and enable are frozen while MDC is high
  a_r3_hold_when_high: assert property (@(posedge clk) disable iff (rst)
    (!$stable(mdio_o) || !$stable(mdio_oe)) |-> !mdc);

  // R7: busy drops exactly with done, done is never seen with busy, pulse is one cycle
  a_r7_fall_with_done: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
  a_r7_done_not_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8: a frame starts only from a request
  a_r8_start_by_req: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(req));

  // R6: error appears only at the end of a frame
  a_r6_err_at_end: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> done);

  // R9: idle bus rests with MDC high and the line released
  a_r9_idle_pins: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (mdc && !mdio_oe));

endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .req     (req),
  .busy    (busy),
  .done    (done),
  .err     (err),
  .mdc     (mdc),
  .mdio_o  (mdio_o),
  .mdio_oe (mdio_oe)
);

// File: tb/tb_mdio_master.sv
`timescale 1ns/1ps
module tb_mdio_master;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] half_div = '0;
  logic        req = 1'b0;
  logic        rd_wr = 1'b0;
  logic [4:0]  phy_addr = '0;
  logic [4:0]  reg_addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        done, err, busy, mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  always #2.5 clk = ~clk;

  mdio_master dut (
    .clk(clk), .rst(rst), .half_div(half_div), .req(req), .rd_wr(rd_wr),
    .phy_addr(phy_addr), .reg_addr(reg_addr), .wdata(wdata), .rdata(rdata),
    .done(done), .err(err), .busy(busy), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  int total = 0;
  int failed = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // PHY model: slot index counts MDC falling edges since the request
  int          ns = 0;
  logic        ta_bad = 1'b0;
  logic [15:0] rd_pat = '0;

  function automatic logic phy_bit(input int s);
    if (s == 46) return ta_bad;
    if (s == 47) return 1'b0;
    if (s >= 48 && s <= 63) return rd_pat[63-s];
    return 1'b1;
  endfunction

  always @(negedge mdc) begin
    mdio_i = phy_bit(ns);
    ns++;
  end

  // capture of the driven line at each MDC rising edge
  logic cap_o  [0:127];
  logic cap_oe [0:127];
  int   rs = 0;
  always @(posedge mdc) begin
    if (rs < 128) begin
      cap_o[rs]  = mdio_o;
      cap_oe[rs] = mdio_oe;
    end
    rs++;
  end

  // busy length and hold-while-high monitor
  int   bc = 0;
  int   viol = 0;
  logic p_mdc = 1'b1, p_o = 1'b1, p_oe = 1'b0;
  always @(negedge clk) begin
    if (busy) bc++;
    if (!rst && mdc && p_mdc && (mdio_o !== p_o || mdio_oe !== p_oe)) viol++;
    p_mdc = mdc;
    p_o   = mdio_o;
    p_oe  = mdio_oe;
  end

  logic [15:0] exp_rdata = '0;

  task automatic launch(input logic r, input logic b, input logic [4:0] p,
                        input logic [4:0] g, input logic [15:0] d, input logic [15:0] dv);
    rd_wr = r; phy_addr = p; reg_addr = g; wdata = d; half_div = dv;
    ta_bad = b; rd_pat = d;
    ns = 0; rs = 0; bc = 0;
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    chk(busy === 1'b1, "R7 busy after accept", busy, 1);
  endtask

  task automatic wait_done();
    int n = 0;
    forever begin
      @(negedge clk);
      if (done === 1'b1) break;
      n++;
      if (n > 4000) begin
        chk(1'b0, "R7 done timeout", 0, 1);
        break;
      end
    end
    chk(busy === 1'b0, "R7 busy low with done", busy, 0);
  endtask

  task automatic frame_check(input logic r, input logic b, input logic [4:0] p,
                             input logic [4:0] g, input logic [15:0] d, input logic [15:0] dv);
    int slots = (r && b) ? 79 : 65;
    int lim = (dv == 0) ? 1 : int'(dv);
    logic [13:0] hdr = {2'b01, (r ? 2'b10 : 2'b01), p, g};
    bit ok;
    chk(rs == slots, r ? (b ? "R6 cycle count" : "R5 cycle count") : "R4 cycle count", rs, slots);
    chk(bc == 2 * lim * slots, "R3 busy length", bc, 2 * lim * slots);
    chk(viol == 0, "R3 change while high", viol, 0);
    ok = 1;
    for (int i = 0; i < 32; i++) if (cap_o[i] !== 1'b1 || cap_oe[i] !== 1'b1) ok = 0;
    chk(ok, "R1 preamble", 0, 0);
    ok = 1;
    for (int i = 0; i < 14; i++) if (cap_o[32+i] !== hdr[13-i] || cap_oe[32+i] !== 1'b1) ok = 0;
    chk(ok, "R2 header", 0, hdr);
    ok = 1;
    if (!r) begin
      if (cap_o[46] !== 1'b1 || cap_o[47] !== 1'b0 || cap_oe[46] !== 1'b1 || cap_oe[47] !== 1'b1) ok = 0;
      for (int i = 0; i < 16; i++) if (cap_o[48+i] !== d[15-i] || cap_oe[48+i] !== 1'b1) ok = 0;
      if (cap_oe[64] !== 1'b0) ok = 0;
      chk(ok, "R4 write tail", 0, d);
      chk(err === 1'b0, "R4 err on write", err, 0);
    end else begin
      for (int i = 46; i < slots; i++) if (cap_oe[i] !== 1'b0) ok = 0;
      chk(ok, b ? "R6 line released" : "R5 line released", 0, 0);
      if (!b) exp_rdata = d;
      chk(err === b, b ? "R6 err flag" : "R5 err flag", err, b);
      chk(rdata === exp_rdata, b ? "R6 rdata kept" : "R5 rdata", rdata, exp_rdata);
    end
    chk(mdc === 1'b1 && mdio_oe === 1'b0, "R9 idle pins", {mdc, mdio_oe}, 2'b10);
  endtask

  // {rd, ta_bad, phy, reg, data, div}
  localparam int VN = 7;
  localparam logic [43:0] VEC [VN] = '{
    {1'b0, 1'b0, 5'h01, 5'h00, 16'hA55A, 16'd0},
    {1'b0, 1'b0, 5'h1F, 5'h15, 16'h8001, 16'd3},
    {1'b1, 1'b0, 5'h03, 5'h02, 16'h1234, 16'd1},
    {1'b0, 1'b0, 5'h10, 5'h01, 16'h0000, 16'd2},
    {1'b1, 1'b1, 5'h05, 5'h0A, 16'hBEEF, 16'd2},
    {1'b1, 1'b0, 5'h1E, 5'h11, 16'hFFFF, 16'd0},
    {1'b1, 1'b0, 5'h00, 5'h1F, 16'h8001, 16'd1}
  };

  task automatic summary();
    $display("%0d/%0d checks passed", total - failed, total);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk(busy === 0 && done === 0 && err === 0, "R9 reset flags", {busy, done, err}, 0);
    chk(rdata === 16'h0, "R9 reset rdata", rdata, 0);
    chk(mdc === 1'b1 && mdio_oe === 1'b0, "R9 reset pins", {mdc, mdio_oe}, 2'b10);

    for (int k = 0; k < VN; k++) begin
      logic [43:0] v = VEC[k];
      launch(v[43], v[42], v[41:37], v[36:32], v[31:16], v[15:0]);
      wait_done();
      frame_check(v[43], v[42], v[41:37], v[36:32], v[31:16], v[15:0]);
      @(negedge clk);
      chk(done === 1'b0, "R7 done single cycle", done, 0);
    end

    // R8: a request during a write is ignored
    launch(1'b0, 1'b0, 5'h0C, 5'h03, 16'h3C5A, 16'd1);
    repeat (20) @(negedge clk);
    rd_wr = 1'b1; phy_addr = 5'h1B; reg_addr = 5'h04; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    wait_done();
    frame_check(1'b0, 1'b0, 5'h0C, 5'h03, 16'h3C5A, 16'd1);
    chk(rs == 65, "R8 frame unchanged", rs, 65);
    @(negedge clk);
    chk(busy === 1'b0, "R8 no second frame", busy, 0);

    // R10: a read request in the done cycle of a write is accepted
    launch(1'b0, 1'b0, 5'h07, 5'h09, 16'hC3C3, 16'd0);
    wait_done();
    frame_check(1'b0, 1'b0, 5'h07, 5'h09, 16'hC3C3, 16'd0);
    launch(1'b1, 1'b0, 5'h0A, 5'h05, 16'h5AA5, 16'd0);
    chk(busy === 1'b1, "R10 back-to-back accept", busy, 1);
    wait_done();
    frame_check(1'b1, 1'b0, 5'h0A, 5'h05, 16'h5AA5, 16'd0);

    // R6 then R5: error clears on the next good read
    launch(1'b1, 1'b1, 5'h02, 5'h02, 16'h0F0F, 16'd0);
    wait_done();
    frame_check(1'b1, 1'b1, 5'h02, 5'h02, 16'h0F0F, 16'd0);
    launch(1'b1, 1'b0, 5'h02, 5'h02, 16'h0F0F, 16'd0);
    wait_done();
    frame_check(1'b1, 1'b0, 5'h02, 5'h02, 16'h0F0F, 16'd0);

    summary();
    $finish;
  end

endmodule